// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block is a streaming filter placed between the byte-wide receive path of an Ethernet MAC and the receive FIFO. It watches each incoming frame, decodes the 16-bit length/type word that follows the two 6-byte addresses, and decides how many bytes the FIFO really needs. When stripping is switched on and the length word shows a frame padded up to the minimum size, only the header and the true data bytes are forwarded. The pad bytes and the trailing 4-byte FCS never reach the FIFO, so they use no FIFO space.

Frames whose length word is 46 or larger pass through whole, with the FCS kept. This includes type values such as 0x0800. Frames received while stripping is off also pass through whole. The output is a registered copy of the input stream with one clock of latency. Some input beats are suppressed, and the end-of-frame flag is moved to the last byte that is kept. CRC checking, address filtering and FIFO control belong to other blocks.

Top module: `rxps_pad_strip`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low, and the next input beat is taken as byte 0 of a frame.
- R2: Every forwarded beat appears on the output exactly one clock after it is accepted, with its data unchanged. `out_last` is asserted only together with `out_valid`.
- R3: Bytes 0 to 13 of a frame (both addresses and the length word) are always forwarded.
- R4: The length word is big-endian: byte 12 is the high byte and byte 13 is the low byte. When stripping applies and the length L is below 46, exactly 14+L bytes are forwarded, and `out_last` marks byte 13+L.
- R5: Once the last kept byte has been forwarded, the remaining input bytes (pad and the 4 FCS bytes) produce no `out_valid`, up to and including the input beat that carries `in_last`.
- R6: When L is 46 or more (including type values of 0x0600 and above), every byte is forwarded, and `out_last` follows `in_last`.
- R7: When `strip_en` is low at byte 0, the whole frame is forwarded unchanged, whatever its length word.
- R8: `strip_en` is sampled only at byte 0 of each frame. Changing it later in the frame has no effect on that frame.
- R9: If the input frame ends before 14+L bytes have arrived, `out_last` is asserted on the final input byte.
- R10: With stripping enabled and L = 0, `out_last` is asserted on byte 13 and nothing after it is forwarded.
- R11: A frame shorter than 14 bytes is forwarded whole, with `out_last` on its final byte.
- R12: Idle cycles (`in_valid` low) inside or between frames do not advance byte counting. The cycle after an idle input cycle has `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strip_en | input | 1 | Pad/FCS stripping enable, sampled at byte 0 of each frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final forwarded byte of the frame |

## Verification
The assertions assume that the receive path delivers whole frames: `in_last` closes every frame, and `in_data` is meaningful only while `in_valid` is high. They also assume that nothing stalls the output, since the block has no backpressure. The stimulus always ends a frame with `in_last`, and it drives `strip_en` and the idle gaps only at the falling clock edge. Lengths are chosen on both sides of 46, at zero, as type values, and larger than the actual frame. This covers every path of the keep/drop decision while the input stays well formed.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    // Frame layout defaults
    localparam int HDR_BYTES_DEF   = 14;  // two addresses plus length word
    localparam int LEN_HI_OFS_DEF  = 12;  // byte offset of the length high byte
    localparam int MIN_PAYLOAD_DEF = 46;  // lengths below this carry pad

    typedef enum logic [1:0] {
        ST_HDR,   // header bytes, decision pending
        ST_PASS,  // forward to end of frame
        ST_KEEP,  // forward counted data bytes
        ST_DROP   // swallow pad and FCS
    } strip_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } beat_t;

    function automatic logic has_pad(input logic [15:0] len, input int min_payload);
        return int'(len) < min_payload;
    endfunction

endpackage

// File: rtl/rxps_hdr_track.sv
module rxps_hdr_track
    import rxps_pkg::*;
#(
    parameter int HDR_BYTES  = HDR_BYTES_DEF,
    parameter int LEN_HI_OFS = LEN_HI_OFS_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strip_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        len_lo_beat,
    output logic [15:0] len_word,
    output logic        frame_en
);
    localparam int IDX_W = $clog2(HDR_BYTES + 1);

    logic [IDX_W-1:0] idx;
    logic             en_q;
    logic [7:0]       len_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            en_q   <= 1'b0;
            len_hi <= '0;
        end else if (in_valid) begin
            if (idx == '0)
                en_q <= strip_en;
            if (idx == IDX_W'(LEN_HI_OFS))
                len_hi <= in_data;
            if (in_last)
                idx <= '0;
            else if (idx != IDX_W'(HDR_BYTES))
                idx <= idx + 1'b1;
        end
    end

    always_comb begin
        frame_en    = (idx == '0) ? strip_en : en_q;
        len_lo_beat = (idx == IDX_W'(LEN_HI_OFS + 1));
        len_word    = {len_hi, in_data};
    end

endmodule

// File: rtl/rxps_keep_ctrl.sv
module rxps_keep_ctrl
    import rxps_pkg::*;
#(
    parameter int MIN_PAYLOAD = MIN_PAYLOAD_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_last,
    input  logic         len_lo_beat,
    input  logic [15:0]  len_word,
    input  logic         frame_en,
    output logic         fwd,
    output logic         keep_end,
    output strip_state_e state,
    output logic [$clog2(MIN_PAYLOAD)-1:0] remain
);
    localparam int REM_W = $clog2(MIN_PAYLOAD);

    strip_state_e      state_n;
    logic [REM_W-1:0]  remain_n;

    always_comb begin
        fwd      = 1'b0;
        keep_end = 1'b0;
        state_n  = state;
        remain_n = remain;
        if (in_valid) begin
            unique case (state)
                ST_HDR: begin
                    fwd = 1'b1;
                    if (len_lo_beat) begin
                        if (frame_en && has_pad(len_word, MIN_PAYLOAD)) begin
                            if (len_word == '0) begin
                                keep_end = 1'b1;
                                state_n  = ST_DROP;
                            end else begin
                                state_n  = ST_KEEP;
                                remain_n = len_word[REM_W-1:0];
                            end
                        end else begin
                            state_n = ST_PASS;
                        end
                    end
                end
                ST_PASS: fwd = 1'b1;
                ST_KEEP: begin
                    fwd      = 1'b1;
                    remain_n = remain - 1'b1;
                    if (remain == REM_W'(1)) begin
                        keep_end = 1'b1;
                        state_n  = ST_DROP;
                    end
                end
                ST_DROP: fwd = 1'b0;
                default: fwd = 1'b0;
            endcase
            if (in_last)
                state_n = ST_HDR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HDR;
            remain <= '0;
        end else begin
            state  <= state_n;
            remain <= remain_n;
        end
    end

endmodule

// File: rtl/rxps_pad_strip.sv
module rxps_pad_strip
    import rxps_pkg::*;
#(
    parameter int HDR_BYTES   = HDR_BYTES_DEF,
    parameter int LEN_HI_OFS  = LEN_HI_OFS_DEF,
    parameter int MIN_PAYLOAD = MIN_PAYLOAD_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strip_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    localparam int REM_W = $clog2(MIN_PAYLOAD);

    logic              len_lo_beat;
    logic [15:0]       len_word;
    logic              frame_en;
    logic              fwd;
    logic              keep_end;
    strip_state_e      state;
    logic [REM_W-1:0]  remain;
    beat_t             out_q;
    logic              out_v_q;

    rxps_hdr_track #(
        .HDR_BYTES  (HDR_BYTES),
        .LEN_HI_OFS (LEN_HI_OFS)
    ) u_hdr (
        .clk         (clk),
        .rst         (rst),
        .strip_en    (strip_en),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .len_lo_beat (len_lo_beat),
        .len_word    (len_word),
        .frame_en    (frame_en)
    );

    rxps_keep_ctrl #(
        .MIN_PAYLOAD (MIN_PAYLOAD)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .len_lo_beat (len_lo_beat),
        .len_word    (len_word),
        .frame_en    (frame_en),
        .fwd         (fwd),
        .keep_end    (keep_end),
        .state       (state),
        .remain      (remain)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v_q <= 1'b0;
            out_q   <= '0;
        end else begin
            out_v_q    <= in_valid && fwd;
            out_q.data <= in_data;
            out_q.last <= in_valid && fwd && (in_last || keep_end);
        end
    end

    always_comb begin
        out_valid = out_v_q;
        out_data  = out_q.data;
        out_last  = out_q.last;
    end

endmodule

// File: rtl/rxps_checker.sv
module rxps_checker
    import rxps_pkg::*;
#(
    parameter int REM_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             out_valid,
    input  logic [7:0]       out_data,
    input  logic             out_last,
    input  strip_state_e     state,
    input  logic [REM_W-1:0] remain
);

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R2

    AST_DATA_DELAYED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data == $past(in_data)); // R2

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R2

    AST_END_ON_IN_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_last)) |-> out_last); // R9

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROP && in_valid) |=> !out_valid); // R5

    AST_PASS_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS && in_valid) |=> (out_valid && out_last == $past(in_last))); // R6

    AST_KEEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state == ST_KEEP |-> remain != '0); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R12

endmodule

bind rxps_pad_strip rxps_checker #(
    .REM_W ($clog2(MIN_PAYLOAD))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .state     (state),
    .remain    (remain)
);

// File: tb/rxps_pad_strip_tb.sv
`timescale 1ns/100ps
module rxps_pad_strip_tb;

    typedef struct {
        bit       v;
        bit [7:0] d;
        bit       l;
        string    req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strip_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    rxps_pad_strip u_dut (
        .clk       (clk),
        .rst       (rst),
        .strip_en  (strip_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // Output is compared against the model on every clock
    always @(posedge clk) begin
        #1;
        if (mon_en && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (out_valid !== e.v ||
                (e.v && (out_data !== e.d || out_last !== e.l))) begin
                errors++;
                $display("FAIL %s: got v=%0b d=%02h l=%0b, expected v=%0b d=%02h l=%0b",
                         e.req, out_valid, out_data, out_last, e.v, e.d, e.l);
            end
        end
    end

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            exp_q.push_back('{v: 1'b0, d: 8'h00, l: 1'b0, req: req});
        end
    endtask

    // n: frame bytes, len: length word, en: strip_en at byte 0,
    // flip: invert strip_en after byte 0, gap: idle cycle after every gap-th byte
    task automatic send_frame(input int n, input int len, input bit en,
                              input bit flip, input int gap, input int seed,
                              input string req);
        bit strip;
        int keep;
        int last_idx;
        strip    = en && (n > 13) && (len < 46);
        keep     = strip ? 14 + len : n;
        last_idx = ((keep < n) ? keep : n) - 1;
        for (int i = 0; i < n; i++) begin
            bit [7:0] b;
            @(negedge clk);
            if (i == 0) strip_en = en;
            else if (i == 1 && flip) strip_en = ~en;
            if (i == 12)      b = 8'((len >> 8) & 255);
            else if (i == 13) b = 8'(len & 255);
            else              b = 8'((i * 7 + seed) & 255);
            in_valid = 1'b1;
            in_data  = b;
            in_last  = (i == n - 1);
            exp_q.push_back('{v: (i < keep), d: b, l: (i == last_idx), req: req});
            if (gap > 0 && (i % gap) == gap - 1 && i != n - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
                exp_q.push_back('{v: 1'b0, d: 8'h00, l: 1'b0, req: "R12"});
            end
        end
        idle(2, req);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_last !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%0b l=%0b, expected v=0 l=0", out_valid, out_last);
        end
        mon_en = 1'b1;

        send_frame(64, 10, 1, 0, 0, 3,  "R4");   // R3 header kept, R5 pad/FCS dropped
        send_frame(64, 0,  1, 0, 0, 5,  "R10");
        send_frame(64, 45, 1, 0, 0, 9,  "R4");
        send_frame(64, 46, 1, 0, 0, 11, "R6");
        send_frame(70, 16'h0800, 1, 0, 0, 13, "R6");
        send_frame(64, 5,  0, 0, 0, 17, "R7");
        send_frame(64, 7,  1, 1, 0, 19, "R8");   // enable drops mid-frame
        send_frame(64, 7,  0, 1, 0, 23, "R8");   // enable rises mid-frame
        send_frame(30, 40, 1, 0, 0, 29, "R9");
        send_frame(14, 20, 1, 0, 0, 31, "R9");
        send_frame(8,  2,  1, 0, 0, 37, "R11");
        send_frame(1,  0,  1, 0, 0, 41, "R11");
        send_frame(64, 3,  1, 0, 3, 43, "R12");
        send_frame(60, 1,  1, 0, 0, 47, "R5");   // back-to-back check of drop then restart
        send_frame(64, 45, 1, 0, 2, 53, "R12");
        idle(4, "R5");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule